// File: doc/BRIEF.md
# Cycle-by-Cycle Current Sense Fault Monitor

This block watches the low-side current sense of a resonant half-bridge once per switching period and decides whether the converter has to be stopped. It receives two comparator flags that are already digital. One flag reports that the sensed current is above the programmable upper limit. The other reports that the current is below the fixed low level. The block also receives the low-side gate drive signal and two enables from the mode sequencer. When it detects a fault, it raises a latched fault level. The sequencer uses that level to stop the oscillator and pull both gate outputs low.

The overcurrent path covers failure to strike, overcurrent and hard switching. The sequencer enables it from the end of filament preheat onward. A raised flag only counts after it has been seen on a programmable number of consecutive clocks, so single-clock glitches are rejected. The undercurrent path covers no-load operation and operation below resonance. It is not continuous: it is sampled once per period, on the falling edge of the low-side drive, and only once run mode has been entered.

The fault stays set until the lamp-removal shutdown input goes high or the supply-low lockout signal is asserted. A two-bit cause field records which check tripped.

Top module: `cs_fault_monitor`

## Requirements
- R1: While reset is asserted, and after its release with no stimulus, `fault` is 0 and `fault_kind` is 2'b00.
- R2: With `over_en` high, when `cs_over` has been high on FILT_LEN (default 2) consecutive rising clock edges, `fault` is 1 right after the last of those edges.
- R3: A `cs_over` assertion shorter than FILT_LEN consecutive edges sets no fault. A gap of one low sample restarts the count.
- R4: `cs_over` has no effect while `over_en` is low.
- R5: The undercurrent check fires at a falling edge of `lo_drv`. A falling edge means `lo_drv` is sampled 1 on one clock edge and 0 on the next. The check uses the `cs_under` value sampled on the clock edge before the falling edge is detected. If that value is 1 and `under_en` is high at the detecting edge, `fault` is 1 right after the detecting edge.
- R6: `cs_under` high at any other time sets no fault. This covers `lo_drv` steady, `lo_drv` rising, and `cs_under` high only on the detecting edge itself.
- R7: `cs_under` has no effect while `under_en` is low.
- R8: Once set, `fault` stays 1 and `fault_kind` keeps its value after both flags return low, for as long as no clear is applied.
- R9: `shdn` or `uv_lock` high on an edge makes `fault` 0 after that edge. A clear wins over a trip on the same edge.
- R10: `fault_kind` is captured when the fault is set and holds until the next clear. Bit 0 means an overcurrent trip and bit 1 means an undercurrent trip. Both bits are set if both checks trip on the same edge, and the field is 2'b00 while no fault is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lo_drv | input | 1 | Low-side gate drive level |
| cs_over | input | 1 | Sensed current above programmable upper limit |
| cs_under | input | 1 | Sensed current below fixed low level |
| over_en | input | 1 | Overcurrent check enable (end of preheat onward) |
| under_en | input | 1 | Undercurrent check enable (run mode) |
| shdn | input | 1 | Shutdown / lamp-removal input, clears the fault |
| uv_lock | input | 1 | Supply below falling lockout threshold, clears the fault |
| fault | output | 1 | Latched fault request to the sequencer |
| fault_kind | output | 2 | Cause of the fault: bit 0 overcurrent, bit 1 undercurrent |

## Verification
Every 4-bit run of `cs_over` samples is swept with the check enabled. The fault level is compared after each edge against a count of adjacent high pairs. This separates a correct two-clock filter from one that trips early, trips late or fails to restart after a gap. The undercurrent path is swept over all 32 combinations of the previous and current `lo_drv` level, the previous and current `cs_under` value, and `under_en`. Only the combination with a falling edge, a high flag one clock earlier, and the enable set may trip, which exposes a check that is level-sensitive, samples the live flag, or ignores the enable. Directed sequences cover clear priority through both clear inputs, fault holding, and the cause field when both checks trip together and when a second event follows an existing fault.

// File: rtl/csm_pkg.sv
package csm_pkg;
    localparam int KIND_W  = 2;
    localparam int KIND_OC = 0;
    localparam int KIND_UC = 1;

    typedef struct packed {
        logic lo;
        logic under;
    } uc_hist_t;

    typedef struct packed {
        logic              fault;
        logic [KIND_W-1:0] kind;
    } fault_state_t;
endpackage

// File: rtl/csm_uc_sampler.sv
module csm_uc_sampler
    import csm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lo_drv,
    input  logic cs_under,
    input  logic under_en,
    output logic trip
);
    uc_hist_t h_d, h_q;
    logic     lo_fall;

    always_comb begin
        h_d       = h_q;
        h_d.lo    = lo_drv;
        h_d.under = cs_under;
        lo_fall   = h_q.lo & ~lo_drv;
        trip      = lo_fall & h_q.under & under_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end
endmodule

// File: rtl/csm_oc_filter.sv
module csm_oc_filter #(
    parameter int FILT_LEN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_over,
    input  logic over_en,
    output logic trip
);
    logic qual;
    assign qual = cs_over & over_en;

    generate
        if (FILT_LEN <= 1) begin : g_direct
            assign trip = qual;
        end else begin : g_count
            localparam int              CW    = $clog2(FILT_LEN + 1);
            localparam logic [CW-1:0]   LIMIT = CW'(FILT_LEN);
            localparam logic [CW-1:0]   ARM   = CW'(FILT_LEN - 1);
            logic [CW-1:0] cnt_d, cnt_q;

            always_comb begin
                cnt_d = cnt_q;
                if (!qual)               cnt_d = '0;
                else if (cnt_q != LIMIT) cnt_d = cnt_q + 1'b1;
                trip = qual && (cnt_q >= ARM);
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end
        end
    endgenerate
endmodule

// File: rtl/csm_fault_latch.sv
module csm_fault_latch
    import csm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trip_oc,
    input  logic              trip_uc,
    input  logic              clr,
    output logic              fault,
    output logic [KIND_W-1:0] fault_kind
);
    fault_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr) begin
            s_d = '0;
        end else if (!s_q.fault && (trip_oc || trip_uc)) begin
            s_d.fault         = 1'b1;
            s_d.kind          = '0;
            s_d.kind[KIND_OC] = trip_oc;
            s_d.kind[KIND_UC] = trip_uc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign fault      = s_q.fault;
    assign fault_kind = s_q.kind;
endmodule

// File: rtl/cs_fault_monitor.sv
module cs_fault_monitor
    import csm_pkg::*;
#(
    parameter int FILT_LEN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lo_drv,
    input  logic              cs_over,
    input  logic              cs_under,
    input  logic              over_en,
    input  logic              under_en,
    input  logic              shdn,
    input  logic              uv_lock,
    output logic              fault,
    output logic [KIND_W-1:0] fault_kind
);
    logic trip_oc, trip_uc, clr;

    assign clr = shdn | uv_lock;

    csm_oc_filter #(.FILT_LEN(FILT_LEN)) u_oc (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_over (cs_over),
        .over_en (over_en),
        .trip    (trip_oc)
    );

    csm_uc_sampler u_uc (
        .clk      (clk),
        .rst_n    (rst_n),
        .lo_drv   (lo_drv),
        .cs_under (cs_under),
        .under_en (under_en),
        .trip     (trip_uc)
    );

    csm_fault_latch u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .trip_oc    (trip_oc),
        .trip_uc    (trip_uc),
        .clr        (clr),
        .fault      (fault),
        .fault_kind (fault_kind)
    );
endmodule

// File: rtl/csm_checker.sv
module csm_checker #(
    parameter int FILT_LEN = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       lo_drv,
    input logic       cs_over,
    input logic       cs_under,
    input logic       over_en,
    input logic       under_en,
    input logic       shdn,
    input logic       uv_lock,
    input logic       fault,
    input logic [1:0] fault_kind
);
    localparam int RW = $clog2(FILT_LEN + 1);
    logic [RW-1:0] run_q;
    logic          lo_prev_q, und_prev_q;
    logic          clr, oc_hit, uc_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q      <= '0;
            lo_prev_q  <= 1'b0;
            und_prev_q <= 1'b0;
        end else begin
            lo_prev_q  <= lo_drv;
            und_prev_q <= cs_under;
            if (!(cs_over && over_en))           run_q <= '0;
            else if (int'(run_q) < FILT_LEN)     run_q <= run_q + 1'b1;
        end
    end

    assign clr    = shdn || uv_lock;
    assign oc_hit = cs_over && over_en && (int'(run_q) >= FILT_LEN - 1);
    assign uc_hit = lo_prev_q && !lo_drv && und_prev_q && under_en;

    a_r2_oc_trip: assert property (@(posedge clk) disable iff (!rst_n)
        oc_hit && !clr |=> fault);

    a_r5_uc_trip: assert property (@(posedge clk) disable iff (!rst_n)
        uc_hit && !clr |=> fault);

    // R3, R4, R6, R7: no fault without a qualified event
    a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !fault && !oc_hit && !uc_hit |=> !fault);

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        fault && !clr |=> fault && $stable(fault_kind));

    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !fault);

    a_r10_kind_set: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> fault_kind != 2'b00);

    a_r10_kind_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !fault |-> fault_kind == 2'b00);
endmodule

bind cs_fault_monitor csm_checker #(.FILT_LEN(FILT_LEN)) u_chk (.*);

// File: tb/tb_cs_fault_monitor.sv
`timescale 1ns/1ps
module tb_cs_fault_monitor;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       lo_drv, cs_over, cs_under, over_en, under_en, shdn, uv_lock;
    logic       fault;
    logic [1:0] fault_kind;
    int         checks = 0;
    int         failures = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    cs_fault_monitor #(.FILT_LEN(2)) dut (
        .clk(clk), .rst_n(rst_n), .lo_drv(lo_drv), .cs_over(cs_over),
        .cs_under(cs_under), .over_en(over_en), .under_en(under_en),
        .shdn(shdn), .uv_lock(uv_lock), .fault(fault), .fault_kind(fault_kind)
    );

    task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: {fault,kind} actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input logic lo, input logic ov, input logic un,
                        input logic oen, input logic uen,
                        input logic sd, input logic uv);
        lo_drv = lo; cs_over = ov; cs_under = un;
        over_en = oen; under_en = uen; shdn = sd; uv_lock = uv;
        @(negedge clk);
    endtask

    task automatic clear_all();
        step(0, 0, 0, 0, 0, 1, 0);
    endtask

    initial begin
        rst_n = 1'b0;
        lo_drv = 0; cs_over = 0; cs_under = 0; over_en = 0; under_en = 0; shdn = 0; uv_lock = 0;
        repeat (3) @(negedge clk);
        chk("R1 in reset", {fault, fault_kind}, 3'b000);
        rst_n = 1'b1;
        step(0, 0, 0, 0, 0, 0, 0);
        chk("R1 after release", {fault, fault_kind}, 3'b000);

        // R2/R3 sweep of all 4-sample overcurrent runs
        for (int p = 0; p < 16; p++) begin
            logic prev, tripped;
            clear_all();
            prev = 1'b0; tripped = 1'b0;
            for (int i = 0; i < 4; i++) begin
                logic b;
                b = p[i];
                step(0, b, 0, 1, 0, 0, 0);
                tripped = tripped | (b & prev);
                prev = b;
                chk(tripped ? "R2 oc trip" : "R3 oc filtered",
                    {fault, fault_kind}, tripped ? 3'b101 : 3'b000);
            end
        end

        // R4: overcurrent ignored when disabled
        clear_all();
        for (int i = 0; i < 4; i++) begin
            step(0, 1, 0, 0, 1, 0, 0);
            chk("R4 oc disabled", {fault, fault_kind}, 3'b000);
        end

        // R5/R6/R7 sweep of undercurrent sampling
        for (int c = 0; c < 32; c++) begin
            logic lp, ln, up, un, ue, e;
            lp = c[0]; ln = c[1]; up = c[2]; un = c[3]; ue = c[4];
            e = lp & ~ln & up & ue;
            clear_all();
            step(lp, 0, up, 0, ue, 0, 0);
            chk("R6 prep no trip", {fault, fault_kind}, 3'b000);
            step(ln, 0, un, 0, ue, 0, 0);
            chk(e ? "R5 uc trip" : (ue ? "R6 uc no edge" : "R7 uc disabled"),
                {fault, fault_kind}, e ? 3'b110 : 3'b000);
            step(0, 0, 0, 0, 0, 0, 0);
            chk("R8 hold after flags drop", {fault, fault_kind}, e ? 3'b110 : 3'b000);
        end

        // R9: clear by uv_lock and by shdn
        clear_all();
        step(0, 1, 0, 1, 0, 0, 0);
        step(0, 1, 0, 1, 0, 0, 0);
        chk("R2 setup", {fault, fault_kind}, 3'b101);
        step(0, 0, 0, 1, 0, 0, 1);
        chk("R9 uv_lock clears", {fault, fault_kind}, 3'b000);
        step(0, 1, 0, 1, 0, 0, 0);
        step(0, 1, 0, 1, 0, 0, 0);
        chk("R8 set again", {fault, fault_kind}, 3'b101);
        step(0, 0, 0, 1, 0, 1, 0);
        chk("R9 shdn clears", {fault, fault_kind}, 3'b000);
        // clear dominates a trip on the same edge
        step(0, 1, 0, 1, 0, 0, 0);
        step(0, 1, 0, 1, 0, 0, 1);
        chk("R9 clear wins", {fault, fault_kind}, 3'b000);
        step(0, 0, 0, 1, 0, 0, 0);
        chk("R9 stays clear", {fault, fault_kind}, 3'b000);

        // R10: simultaneous trip captures both causes
        clear_all();
        step(1, 1, 1, 1, 1, 0, 0);
        chk("R10 none yet", {fault, fault_kind}, 3'b000);
        step(0, 1, 0, 1, 1, 0, 0);
        chk("R10 both causes", {fault, fault_kind}, 3'b111);

        // R10: later event does not alter captured cause
        clear_all();
        step(0, 1, 0, 1, 1, 0, 0);
        step(1, 1, 1, 1, 1, 0, 0);
        chk("R10 oc cause", {fault, fault_kind}, 3'b101);
        step(0, 0, 0, 1, 1, 0, 0);
        chk("R10 cause held", {fault, fault_kind}, 3'b101);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule